// File: doc/BRIEF.md
# Single-Port Synchronous RAM with Selectable Collision Behaviour

This block is a word-addressed storage array with a single address bus. Reads and writes use that same address. A request is a memory-enable pulse with an address, a write-data word and a byte-lane write mask. A request with a non-zero mask writes the selected lanes. Every enabled request also produces read data on the output.

Three build-time choices shape the read side.

- **Collision policy.** A parameter picks what the output shows on a cycle that writes:
  - the word as it was before the write (old-data),
  - the word as it is after the write (new-data),
  - or the previous output, left untouched (hold).
- **Request register.** It can be placed on the request side.
- **Data register.** It can be placed on the data side.

The read latency is the number of those two registers that are present: one or two cycles. At least one must be present.

The block is built from three parts:

- a request stage with a register that can be bypassed,
- the array with its lane-merge and collision-policy logic,
- an output stage that holds its value when no load is due.

None of these parts is a state machine. The only sequencing is the pipeline depth chosen by the parameters.

Top module: `spram_core`

## Requirements
- R1: A synchronous reset clears the read output to zero. The output stays zero until the first enabled request reaches it.
- R2: Read data for a request appears after exactly IN_REG + OUT_REG clock edges, counted from the edge that samples the request.
- R3: With the old-data policy (MODE = RDW_READ_FIRST, code 0), a request that writes returns the word stored before that write.
- R4: With the new-data policy (MODE = RDW_WRITE_FIRST, code 1), a request that writes returns the merged word that it leaves in the array.
- R5: With the hold policy (MODE = RDW_NO_CHANGE, code 2), the output keeps its previous value for a request that writes. The array is still updated.
- R6: Write-mask bit i controls bits [8i+7:8i] of the word; bit 0 is the least significant byte. Lanes whose mask bit is 0 keep their stored contents.
- R7: While the memory enable is low, the array is not written, whatever the mask says, and the output does not change.
- R8: Reset does not alter the array contents. Words written before a reset read back unchanged after it.
- R9: An enabled request with an all-zero mask returns the stored word in every policy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the output and the pipeline controls |
| en | input | 1 | Memory enable; a low level makes the cycle idle |
| we | input | LANES | Byte-lane write mask; bit i covers byte i |
| addr | input | ADDR_W | Shared word address, ADDR_W = clog2(DEPTH) |
| din | input | 8*LANES | Write data |
| dout | output | 8*LANES | Read data |

## Verification
The bench builds three copies, each 32 bits wide (four lanes) and 16 words deep:

| Copy | Policy | Request register | Data register | Latency |
|------|--------|------------------|---------------|---------|
| 1 | new-data | no | yes | one cycle |
| 2 | old-data | yes | no | one cycle |
| 3 | hold | yes | yes | two cycles |

This set covers all three collision policies. It also puts both single-register placements next to the two-register pipeline. The four-lane width makes partial masks meaningful: a single byte, alternating lanes, and an all-zero mask.

All three copies receive the same stimulus. The shallow depth makes the random traffic return to the same addresses often, so back-to-back writes and reads to one word occur in every copy.

// File: rtl/spram_pkg.sv
package spram_pkg;

    // Collision policy: what the read data shows on a cycle that writes.
    typedef enum logic [1:0] {
        RDW_READ_FIRST  = 2'd0,
        RDW_WRITE_FIRST = 2'd1,
        RDW_NO_CHANGE   = 2'd2
    } rdw_mode_e;

    localparam int unsigned LANE_W = 8;

endpackage

// File: rtl/spram_req_stage.sv
module spram_req_stage #(
    parameter int unsigned LANES  = 1,
    parameter int unsigned ADDR_W = 6,
    parameter bit          ENABLE = 1'b0,
    localparam int unsigned DATA_W = spram_pkg::LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic [LANES-1:0]  we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] din_i,
    output logic              en_o,
    output logic [LANES-1:0]  we_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] din_o
);

    logic              en_r;
    logic [LANES-1:0]  we_r;
    logic [ADDR_W-1:0] addr_r;
    logic [DATA_W-1:0] din_r;

    // Control bits are cleared by reset so that no stray write follows it.
    always_ff @(posedge clk) begin
        if (rst) begin
            en_r <= 1'b0;
            we_r <= '0;
        end else begin
            en_r <= en_i;
            we_r <= we_i;
        end
    end

    always_ff @(posedge clk) begin
        addr_r <= addr_i;
        din_r  <= din_i;
    end

    assign en_o   = ENABLE ? en_r   : en_i;
    assign we_o   = ENABLE ? we_r   : we_i;
    assign addr_o = ENABLE ? addr_r : addr_i;
    assign din_o  = ENABLE ? din_r  : din_i;

endmodule

// File: rtl/spram_array.sv
module spram_array #(
    parameter int unsigned          LANES  = 1,
    parameter int unsigned          DEPTH  = 64,
    parameter int unsigned          ADDR_W = 6,
    parameter spram_pkg::rdw_mode_e MODE   = spram_pkg::RDW_READ_FIRST,
    localparam int unsigned DATA_W = spram_pkg::LANE_W * LANES,
    localparam int unsigned LW     = spram_pkg::LANE_W
) (
    input  logic              clk,
    input  logic              en,
    input  logic [LANES-1:0]  we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] view,
    output logic              load
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] stored;
    logic [DATA_W-1:0] merged;

    assign stored = mem[addr];

    // Lane-masked write; contents are never touched by reset.
    always_ff @(posedge clk) begin
        if (en) begin
            for (int l = 0; l < LANES; l++) begin
                if (we[l]) mem[addr][l*LW +: LW] <= din[l*LW +: LW];
            end
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_merge
        assign merged[g*LW +: LW] = we[g] ? din[g*LW +: LW] : stored[g*LW +: LW];
    end

    always_comb begin
        unique case (MODE)
            spram_pkg::RDW_WRITE_FIRST: view = merged;
            default:                    view = stored;
        endcase
    end

    assign load = en && !((MODE == spram_pkg::RDW_NO_CHANGE) && (|we));

endmodule

// File: rtl/spram_out_stage.sv
module spram_out_stage #(
    parameter int unsigned DATA_W     = 8,
    parameter bit          REGISTERED = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] view,
    input  logic              load,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] held;

    always_ff @(posedge clk) begin
        if (rst)       held <= '0;
        else if (load) held <= view;
    end

    // Without the data register the output follows the array while a load
    // is due and otherwise shows the last loaded word.
    assign dout = REGISTERED ? held : (load ? view : held);

endmodule

// File: rtl/spram_core.sv
module spram_core #(
    parameter int unsigned          LANES   = 1,
    parameter int unsigned          DEPTH   = 64,
    parameter spram_pkg::rdw_mode_e MODE    = spram_pkg::RDW_READ_FIRST,
    parameter bit                   IN_REG  = 1'b0,
    parameter bit                   OUT_REG = 1'b1,
    localparam int unsigned DATA_W = spram_pkg::LANE_W * LANES,
    localparam int unsigned ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [LANES-1:0]  we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    logic              q_en;
    logic [LANES-1:0]  q_we;
    logic [ADDR_W-1:0] q_addr;
    logic [DATA_W-1:0] q_din;
    logic [DATA_W-1:0] view;
    logic              load;

    spram_req_stage #(
        .LANES (LANES),
        .ADDR_W(ADDR_W),
        .ENABLE(IN_REG)
    ) i_req (
        .clk   (clk),
        .rst   (rst),
        .en_i  (en),
        .we_i  (we),
        .addr_i(addr),
        .din_i (din),
        .en_o  (q_en),
        .we_o  (q_we),
        .addr_o(q_addr),
        .din_o (q_din)
    );

    spram_array #(
        .LANES (LANES),
        .DEPTH (DEPTH),
        .ADDR_W(ADDR_W),
        .MODE  (MODE)
    ) i_array (
        .clk (clk),
        .en  (q_en),
        .we  (q_we),
        .addr(q_addr),
        .din (q_din),
        .view(view),
        .load(load)
    );

    spram_out_stage #(
        .DATA_W    (DATA_W),
        .REGISTERED(OUT_REG)
    ) i_out (
        .clk (clk),
        .rst (rst),
        .view(view),
        .load(load),
        .dout(dout)
    );

endmodule

// File: rtl/spram_core_chk.sv
module spram_core_chk #(
    parameter int unsigned          LANES   = 1,
    parameter spram_pkg::rdw_mode_e MODE    = spram_pkg::RDW_READ_FIRST,
    parameter bit                   IN_REG  = 1'b0,
    parameter bit                   OUT_REG = 1'b1,
    localparam int unsigned DATA_W = spram_pkg::LANE_W * LANES,
    localparam int unsigned LAT    = int'(IN_REG) + int'(OUT_REG)
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic [LANES-1:0]  we,
    input logic [DATA_W-1:0] din,
    input logic [DATA_W-1:0] dout
);

    logic              en_q1, en_q2;
    logic [LANES-1:0]  we_q1, we_q2;
    logic [DATA_W-1:0] din_q1, din_q2;
    logic [1:0]        settle;
    logic              settled;
    logic              en_lat;
    logic [LANES-1:0]  we_lat;
    logic [DATA_W-1:0] din_lat;

    // Request history, so that each output can be matched to its request.
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q1  <= 1'b0;
            en_q2  <= 1'b0;
            we_q1  <= '0;
            we_q2  <= '0;
            settle <= '0;
        end else begin
            en_q1 <= en;
            en_q2 <= en_q1;
            we_q1 <= we;
            we_q2 <= we_q1;
            if (settle != 2'd3) settle <= settle + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        din_q1 <= din;
        din_q2 <= din_q1;
    end

    assign settled = (settle == 2'd3);
    assign en_lat  = (LAT == 2) ? en_q2  : en_q1;
    assign we_lat  = (LAT == 2) ? we_q2  : we_q1;
    assign din_lat = (LAT == 2) ? din_q2 : din_q1;

    // R1: reset clears the output
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (dout == '0));

    // R7: an idle request leaves the output alone
    a_r7_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (settled && !en_lat) |-> $stable(dout));

    // R5: hold policy keeps the output on a writing request
    a_r5_nochange_holds: assert property (@(posedge clk) disable iff (rst)
        ((MODE == spram_pkg::RDW_NO_CHANGE) && settled && en_lat && (|we_lat))
        |-> $stable(dout));

    // R4: new-data policy with a full mask returns the written word
    a_r4_write_first_full: assert property (@(posedge clk) disable iff (rst)
        ((MODE == spram_pkg::RDW_WRITE_FIRST) && settled && en_lat && (&we_lat))
        |-> (dout == din_lat));

endmodule

bind spram_core spram_core_chk #(
    .LANES  (LANES),
    .MODE   (MODE),
    .IN_REG (IN_REG),
    .OUT_REG(OUT_REG)
) i_chk (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .we  (we),
    .din (din),
    .dout(dout)
);

// File: tb/test_spram_core.sv
module test_spram_core;
    import spram_pkg::*;

    localparam int LANES = 4;
    localparam int DEPTH = 16;
    localparam int DW    = 32;
    localparam int AW    = 4;
    localparam int NCFG  = 3;

    // Per-copy settings: 0 new-data/out reg, 1 old-data/in reg, 2 hold/both.
    localparam int CIN  [NCFG] = '{0, 1, 1};
    localparam int COUT [NCFG] = '{1, 0, 1};
    localparam int CMODE[NCFG] = '{1, 0, 2};

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst  = 1'b1;
    logic          en   = 1'b0;
    logic [3:0]    we   = '0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din  = '0;
    logic [DW-1:0] dout0, dout1, dout2;

    spram_core #(.LANES(LANES), .DEPTH(DEPTH), .MODE(RDW_WRITE_FIRST),
                 .IN_REG(1'b0), .OUT_REG(1'b1)) i_spram_core (
        .clk(clk), .rst(rst), .en(en), .we(we), .addr(addr), .din(din), .dout(dout0));

    spram_core #(.LANES(LANES), .DEPTH(DEPTH), .MODE(RDW_READ_FIRST),
                 .IN_REG(1'b1), .OUT_REG(1'b0)) i_spram_core_rf (
        .clk(clk), .rst(rst), .en(en), .we(we), .addr(addr), .din(din), .dout(dout1));

    spram_core #(.LANES(LANES), .DEPTH(DEPTH), .MODE(RDW_NO_CHANGE),
                 .IN_REG(1'b1), .OUT_REG(1'b1)) i_spram_core_nc (
        .clk(clk), .rst(rst), .en(en), .we(we), .addr(addr), .din(din), .dout(dout2));

    // Behavioural reference state
    logic [DW-1:0] mmem [NCFG][DEPTH];
    logic          r_en   [NCFG];
    logic [3:0]    r_we   [NCFG];
    logic [AW-1:0] r_addr [NCFG];
    logic [DW-1:0] r_din  [NCFG];
    logic [DW-1:0] r_out  [NCFG];

    int    checks = 0;
    int    errors = 0;
    bit    cmp_on = 0;
    string tag    = "R1";

    function automatic logic [DW-1:0] ref_view(int c, logic [3:0] w,
                                               logic [AW-1:0] a, logic [DW-1:0] d);
        logic [DW-1:0] v;
        v = mmem[c][a];
        if (CMODE[c] == 1)
            for (int l = 0; l < LANES; l++)
                if (w[l]) v[l*8 +: 8] = d[l*8 +: 8];
        return v;
    endfunction

    function automatic bit ref_load(int c, logic e, logic [3:0] w);
        return e && !((CMODE[c] == 2) && (w != 0));
    endfunction

    function automatic logic [DW-1:0] ref_expect(int c);
        if (COUT[c] == 1) return r_out[c];
        if (ref_load(c, r_en[c], r_we[c]))
            return ref_view(c, r_we[c], r_addr[c], r_din[c]);
        return r_out[c];
    endfunction

    initial begin
        for (int c = 0; c < NCFG; c++) begin
            r_en[c] = 0; r_we[c] = 0; r_addr[c] = 0; r_din[c] = 0; r_out[c] = 0;
            for (int i = 0; i < DEPTH; i++) mmem[c][i] = 0;
        end
    end

    always @(posedge clk) begin
        for (int c = 0; c < NCFG; c++) begin
            logic          e;
            logic [3:0]    w;
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            e = (CIN[c] == 1) ? r_en[c]   : en;
            w = (CIN[c] == 1) ? r_we[c]   : we;
            a = (CIN[c] == 1) ? r_addr[c] : addr;
            d = (CIN[c] == 1) ? r_din[c]  : din;
            if (rst) r_out[c] = 0;
            else if (ref_load(c, e, w)) r_out[c] = ref_view(c, w, a, d);
            if (e)
                for (int l = 0; l < LANES; l++)
                    if (w[l]) mmem[c][a][l*8 +: 8] = d[l*8 +: 8];
            if (CIN[c] == 1) begin
                r_en[c]   = rst ? 1'b0 : en;
                r_we[c]   = rst ? 4'b0 : we;
                r_addr[c] = addr;
                r_din[c]  = din;
            end
        end
    end

    task automatic check_all();
        logic [DW-1:0] act [NCFG];
        act[0] = dout0; act[1] = dout1; act[2] = dout2;
        for (int c = 0; c < NCFG; c++) begin
            logic [DW-1:0] exp_v;
            exp_v = ref_expect(c);
            checks++;
            if (act[c] !== exp_v) begin
                errors++;
                $display("FAIL %s copy %0d: actual %h expected %h", tag, c, act[c], exp_v);
            end
        end
    endtask

    // One cycle: check outputs at the falling edge, then drive the next request.
    task automatic step(logic e, logic [3:0] w, logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        if (cmp_on) check_all();
        en = e; we = w; addr = a; din = d;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b0, 4'b0, '0, '0);
    endtask

    bit done = 0;

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: output is zero after reset
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tag = "R1";
        cmp_on = 1;
        idle(3);

        // Fill every word so that all later reads are defined
        cmp_on = 0;
        for (int i = 0; i < DEPTH; i++)
            step(1'b1, 4'hF, AW'(i), 32'h1000_0000 + DW'(i * 32'h0101_0101));
        idle(3);
        cmp_on = 1;

        // R9 and R2: plain reads appear after the configured latency
        tag = "R9 R2";
        for (int i = 0; i < DEPTH; i++) step(1'b1, 4'h0, AW'(i), 32'hDEAD_BEEF);
        idle(3);

        // R3, R4, R5: full write collides with the read on the same address
        tag = "R3 R4 R5 full-mask collision";
        step(1'b1, 4'hF, 4'd1, 32'hA1B2_C3D4);
        step(1'b1, 4'hF, 4'd1, 32'h5566_7788);
        step(1'b1, 4'h0, 4'd1, 32'h0);
        idle(3);

        // R6: partial lane writes, lane 0 is the least significant byte
        tag = "R6 lane mask";
        step(1'b1, 4'b0101, 4'd1, 32'h1122_3344);
        step(1'b1, 4'h0,    4'd1, 32'h0);
        step(1'b1, 4'b1000, 4'd2, 32'hFF00_0000);
        step(1'b1, 4'b0001, 4'd2, 32'h0000_00EE);
        step(1'b1, 4'h0,    4'd2, 32'h0);
        idle(3);

        // R7: enable low blocks the write and freezes the output
        tag = "R7 idle";
        step(1'b1, 4'h0, 4'd3, 32'h0);
        step(1'b0, 4'hF, 4'd3, 32'hCAFE_F00D);
        step(1'b0, 4'hF, 4'd3, 32'hCAFE_F00D);
        step(1'b0, 4'h0, 4'd4, 32'h0);
        step(1'b1, 4'h0, 4'd3, 32'h0);
        idle(3);

        // Mixed random traffic on a shallow array
        tag = "R2 R3 R4 R5 R6 R7 random";
        for (int i = 0; i < 600; i++)
            step(1'($urandom_range(0, 3) != 0), 4'($urandom), AW'($urandom), DW'($urandom));
        idle(3);

        // R1 and R8: reset mid-run clears the output but keeps the contents
        tag = "R1 mid-run reset";
        @(negedge clk);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(3);
        tag = "R8 contents after reset";
        for (int i = 0; i < DEPTH; i++) step(1'b1, 4'h0, AW'(i), 32'h0);
        idle(3);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule